// File: doc/BRIEF.md
# Prescaled 10-bit PWM Timer

This block produces a pulse-width-modulated output from an up-counter. The counter advances on ticks from a prescaler that divides the system clock by 1, 2 or 16. The period and the duty are each 10 bits wide. Their low 8 bits sit in two byte registers. Their top 2 bits share one high-bits register, which also holds the enable for a period-match pulse.

Software writes registers through a simple port made of an address, a data byte and a write strobe. Period and duty writes go to master copies. These copies move into the compare registers only when the period rolls over, so a change never cuts a cycle short. A polarity bit picks whether the duty interval is driven high or low. The remaining control bits start, pause and clear the counter, and gate the output.

Top module: `pwmTimer`

Register map. Writes only; there is no read path.

| Address | Contents |
|---|---|
| 0 | control: bit7 polarity, bit5 output enable, bits[3:2] clock select, bit1 continue, bit0 start; bits 6 and 4 are ignored |
| 1 | period, low 8 bits |
| 2 | duty, low 8 bits |
| 3 | high bits: bit7 period-match pulse enable, bits[3:2] period[9:8], bits[1:0] duty[9:8]; bits 6:4 are ignored |

## Requirements
- R1: After reset all registers are zero, and `pwmOut` and `periodPulse` are 0.
- R2: Clock select 0 gives one counter tick per clock. Select 1 gives one tick every 2 clocks. Select 2 and select 3 give one tick every 16 clocks.
- R3: The period value P is {address3 bits[3:2], address1}. The counter runs from 0 to P and then wraps to 0, so one PWM period lasts (P+1) ticks.
- R4: The duty value D is {address3 bits[1:0], address2}. When 0 < D < P, the output is active for exactly D ticks of each period, starting at counter value 0.
- R5: With polarity 1 the active level is high. With polarity 0 the active level is low.
- R6: D = 0 holds the output constantly inactive. D >= P holds it constantly active.
- R7: A write to the period, duty or high-bits register changes nothing in the period already running. The new values take effect from the next wrap.
- R8: While start (control bit 0) is 0, the counter and prescaler stay cleared, the output sits at its inactive level, and no pulse is produced. After start is set, the first wrap comes exactly P+1 ticks later.
- R9: With start = 1 and continue (control bit 1) = 0, counting pauses. The output holds its level and no pulse is produced.
- R10: `periodPulse` is high for one clock on each wrap, and only when the pulse enable (address 3 bit 7) is 1.
- R11: When the output enable (control bit 5) is 0, `pwmOut` is 0 whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | PWM waveform |
| periodPulse | output | 1 | One-clock pulse on each period wrap |

## Verification
The bench measures whole periods between pulses at every divider setting. This catches a tap that is off by one, or a counter that wraps at P instead of P+1. It writes a new duty in the middle of a period and checks that the old duty still governs that period; an unbuffered design would show a mixed active count. It also drives the duty extremes (zero, equal to P, above P) and the 10-bit values that use the high bits. A comparator that is narrow or misordered would show up as a wrong active count or as a stray pulse. Pause, stop/restart, active-low polarity and the two enables are each observed at the pins, so a gate that is missing leaves a visible pulse or level.

// File: rtl/pwmTimerPkg.sv
package pwmTimerPkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PER_LO = 2'd1;
  localparam logic [1:0] ADDR_DUTY_LO = 2'd2;
  localparam logic [1:0] ADDR_HIGH   = 2'd3;

  typedef struct packed {
    logic tick;
    logic clr;
    logic pol;
    logic outEn;
    logic pulseEn;
  } pwmStrobe_t;
endpackage

// File: rtl/pwmTimerCtrl.sv
module pwmTimerCtrl
  import pwmTimerPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 10,
  parameter int DIV_MID  = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  perMaster,
  output logic [CNT_W-1:0]  dutyMaster,
  output pwmStrobe_t        strobe
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] MID_MASK  = PRE_W'(DIV_MID - 1);
  localparam logic [PRE_W-1:0] SLOW_MASK = PRE_W'(DIV_SLOW - 1);

  logic              polQ, outEnQ, contQ, startQ, pulseEnQ;
  logic [1:0]        selQ;
  logic [DATA_W-1:0] perLoQ, dutyLoQ;
  logic [HI_W-1:0]   perHiQ, dutyHiQ;
  logic [PRE_W-1:0]  preQ;
  logic              run, tap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ <= 1'b0; outEnQ <= 1'b0; selQ <= '0; contQ <= 1'b0; startQ <= 1'b0;
      perLoQ <= '0; dutyLoQ <= '0; perHiQ <= '0; dutyHiQ <= '0; pulseEnQ <= 1'b0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL: begin
          polQ   <= wrData[7];
          outEnQ <= wrData[5];
          selQ   <= wrData[3:2];
          contQ  <= wrData[1];
          startQ <= wrData[0];
        end
        ADDR_PER_LO:  perLoQ  <= wrData;
        ADDR_DUTY_LO: dutyLoQ <= wrData;
        default: begin
          pulseEnQ <= wrData[DATA_W-1];
          perHiQ   <= wrData[2*HI_W-1:HI_W];
          dutyHiQ  <= wrData[HI_W-1:0];
        end
      endcase
    end
  end

  assign run = startQ & contQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preQ <= '0;
    else if (!startQ) preQ <= '0;
    else if (run)     preQ <= preQ + 1'b1;
  end

  always_comb begin
    unique case (selQ)
      2'd0:    tap = 1'b1;
      2'd1:    tap = (preQ & MID_MASK) == MID_MASK;
      default: tap = (preQ & SLOW_MASK) == SLOW_MASK;
    endcase
  end

  assign perMaster      = {perHiQ, perLoQ};
  assign dutyMaster     = {dutyHiQ, dutyLoQ};
  assign strobe.tick    = run & tap;
  assign strobe.clr     = ~startQ;
  assign strobe.pol     = polQ;
  assign strobe.outEn   = outEnQ;
  assign strobe.pulseEn = pulseEnQ;

  a_r8_prescaler_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !startQ |=> preQ == '0);
  a_r9_prescaler_paused: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && !contQ && !wrEn) |=> $stable(preQ));
endmodule

// File: rtl/pwmTimerDatapath.sv
module pwmTimerDatapath
  import pwmTimerPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] perMaster,
  input  logic [CNT_W-1:0] dutyMaster,
  input  pwmStrobe_t       strobe,
  output logic             pwmOut,
  output logic             periodPulse
);
  logic [CNT_W-1:0] cntQ, perQ, dutyQ;
  logic [CNT_W-1:0] cntN, perN, dutyN;
  logic             wrap, load, activeN, outQ, pulseQ;

  assign wrap = strobe.tick && (cntQ == perQ);
  assign load = strobe.clr || wrap;
  assign perN  = load ? perMaster  : perQ;
  assign dutyN = load ? dutyMaster : dutyQ;

  always_comb begin
    if (strobe.clr || wrap) cntN = '0;
    else if (strobe.tick)   cntN = cntQ + 1'b1;
    else                    cntN = cntQ;
  end

  assign activeN = (dutyN != '0) && ((cntN < dutyN) || (dutyN >= perN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0; perQ <= '0; dutyQ <= '0; outQ <= 1'b0; pulseQ <= 1'b0;
    end else begin
      cntQ   <= cntN;
      perQ   <= perN;
      dutyQ  <= dutyN;
      pulseQ <= wrap && strobe.pulseEn;
      if (!strobe.outEn)   outQ <= 1'b0;
      else if (strobe.clr) outQ <= ~strobe.pol;
      else                 outQ <= activeN ? strobe.pol : ~strobe.pol;
    end
  end

  assign pwmOut      = outQ;
  assign periodPulse = pulseQ;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= perQ);
  a_r7_slaves_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !strobe.tick) |=> ($stable(perQ) && $stable(dutyQ)));
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (cntQ == '0 && !periodPulse));
  a_r9_count_paused: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !strobe.tick) |=> ($stable(cntQ) && !periodPulse));
  a_r11_output_gated: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |=> !pwmOut);
endmodule

// File: rtl/pwmTimer.sv
module pwmTimer
  import pwmTimerPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 10,
  parameter int DIV_MID  = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmOut,
  output logic              periodPulse
);
  logic [CNT_W-1:0] perMaster, dutyMaster;
  pwmStrobe_t       strobe;

  pwmTimerCtrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .perMaster(perMaster), .dutyMaster(dutyMaster), .strobe(strobe)
  );

  pwmTimerDatapath #(.CNT_W(CNT_W)) datapath (
    .clk(clk), .rstN(rstN), .perMaster(perMaster), .dutyMaster(dutyMaster),
    .strobe(strobe), .pwmOut(pwmOut), .periodPulse(periodPulse)
  );
endmodule

// File: tb/pwmTimer_test.sv
`timescale 1ns/1ps
module pwmTimer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut, periodPulse;

  int checks = 0;
  int fails = 0;

  pwmTimer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .periodPulse(periodPulse)
  );

  always #2 clk = ~clk;

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrlByte(input bit pol, input bit oe,
                                          input int sel, input bit cont, input bit start);
    return {pol, 1'b0, oe, 1'b0, 2'(sel), cont, start};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(input bit pol, input bit oe, input int sel,
                     input int per, input int duty, input bit pen);
    wr(2'd0, ctrlByte(pol, oe, sel, 1'b0, 1'b0));
    wr(2'd3, {pen, 3'b000, 2'(per >> 8), 2'(duty >> 8)});
    wr(2'd1, 8'(per));
    wr(2'd2, 8'(duty));
    wr(2'd0, ctrlByte(pol, oe, sel, 1'b1, 1'b1));
  endtask

  task automatic waitPulse(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (periodPulse) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // window of n samples starting on a pulse sample; optional write at sample wrAt
  task automatic measure(input int n, input bit pol, input int wrAt,
                         input logic [1:0] a, input logic [7:0] d,
                         output int act, output int pls, output bit nextPulse);
    bit seen;
    act = 0; pls = 0;
    waitPulse(seen);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (pwmOut == pol) act++;
      if (periodPulse) pls++;
      if (i == wrAt) begin wrAddr = a; wrData = d; wrEn = 1'b1; end
      if (i == wrAt + 1) wrEn = 1'b0;
    end
    @(negedge clk);
    nextPulse = periodPulse;
  endtask

  task automatic runCase(input string tag, input bit pol, input int sel, input int per,
                         input int duty, input int div, input int expAct);
    int act, pls;
    bit nxt;
    cfg(pol, 1'b1, sel, per, duty, 1'b1);
    measure((per + 1) * div, pol, -1, 2'd0, 8'd0, act, pls, nxt);
    chk(act == expAct, {tag, " active count"}, act, expAct);
    chk(pls == 1 && nxt, {tag, " period length R3"}, pls + 10 * int'(nxt), 11);
  endtask

  task automatic testReset();
    chk(pwmOut == 1'b0, "R1 pwmOut after reset", pwmOut, 0);
    chk(periodPulse == 1'b0, "R1 periodPulse after reset", periodPulse, 0);
  endtask

  task automatic testDividers();
    runCase("R4 div1", 1'b1, 0, 19, 5, 1, 5);
    runCase("R2 div2", 1'b1, 1, 19, 5, 2, 10);
    runCase("R2 div16", 1'b1, 2, 9, 3, 16, 48);
    runCase("R2 select3", 1'b1, 3, 9, 3, 16, 48);
  endtask

  task automatic testWide();
    runCase("R3 R4 ten-bit", 1'b1, 0, 517, 288, 1, 288);
    runCase("R3 R4 top-range", 1'b1, 0, 1023, 700, 1, 700);
  endtask

  task automatic testPolarity();
    runCase("R5 active-low", 1'b0, 0, 19, 5, 1, 5);
    runCase("R5 active-low div2", 1'b0, 1, 15, 9, 2, 18);
  endtask

  task automatic testExtremes();
    runCase("R6 zero duty", 1'b1, 0, 19, 0, 1, 0);
    runCase("R6 duty equals period", 1'b1, 0, 19, 19, 1, 20);
    runCase("R6 duty above period", 1'b1, 0, 19, 25, 1, 20);
  endtask

  task automatic testBuffered();
    int act, pls;
    bit nxt;
    cfg(1'b1, 1'b1, 0, 19, 5, 1'b1);
    measure(20, 1'b1, 3, 2'd2, 8'd12, act, pls, nxt);
    chk(act == 5, "R7 old duty kept this period", act, 5);
    measure(20, 1'b1, -1, 2'd0, 8'd0, act, pls, nxt);
    chk(act == 12, "R7 new duty next period", act, 12);
    measure(20, 1'b1, 4, 2'd1, 8'd29, act, pls, nxt);
    chk(nxt, "R7 old period kept this period", int'(nxt), 1);
    measure(30, 1'b1, -1, 2'd0, 8'd0, act, pls, nxt);
    chk(pls == 1 && nxt, "R7 new period next", pls + 10 * int'(nxt), 11);
  endtask

  task automatic testStopRestart();
    int bad, k;
    bad = 0;
    cfg(1'b1, 1'b1, 0, 19, 5, 1'b1);
    wr(2'd0, ctrlByte(1'b1, 1'b1, 0, 1'b1, 1'b0));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut !== 1'b0 || periodPulse !== 1'b0) bad++;
    end
    chk(bad == 0, "R8 stopped holds inactive, no pulse", bad, 0);
    wr(2'd0, ctrlByte(1'b1, 1'b1, 0, 1'b1, 1'b1));
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      k++;
      if (periodPulse) break;
    end
    chk(k == 20, "R8 first wrap after restart", k, 20);
  endtask

  task automatic testPause();
    int bad;
    logic held;
    bit seen;
    cfg(1'b1, 1'b1, 0, 19, 10, 1'b1);
    waitPulse(seen);
    @(negedge clk);
    @(negedge clk);
    wr(2'd0, ctrlByte(1'b1, 1'b1, 0, 1'b0, 1'b1));
    held = pwmOut;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut !== held || periodPulse) bad++;
    end
    chk(bad == 0, "R9 paused output frozen, no pulse", bad, 0);
    chk(held == 1'b1, "R9 paused level kept active", held, 1);
  endtask

  task automatic testEnables();
    int pls, act;
    cfg(1'b1, 1'b1, 0, 19, 5, 1'b0);
    pls = 0; act = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (periodPulse) pls++;
      if (pwmOut) act++;
    end
    chk(pls == 0, "R10 no pulse when disabled", pls, 0);
    chk(act == 25, "R10 output still runs", act, 25);
    cfg(1'b0, 1'b0, 0, 19, 5, 1'b1);
    act = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOut) act++;
    end
    chk(act == 0, "R11 output gated low", act, 0);
  endtask

  task automatic testPulseWidth();
    int bad;
    bit seen;
    cfg(1'b1, 1'b1, 1, 7, 3, 1'b1);
    bad = 0;
    for (int r = 0; r < 3; r++) begin
      waitPulse(seen);
      @(negedge clk);
      if (periodPulse || !seen) bad++;
    end
    chk(bad == 0, "R10 pulse lasts one clock", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDividers();
    testWide();
    testPolarity();
    testExtremes();
    testBuffered();
    testStopRestart();
    testPause();
    testEnables();
    testPulseWidth();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule